// File: doc/BRIEF.md
# Configurable Look-Up-Table Logic Cell

A single programmable logic cell for a fabric of identical cells. It holds two 4-input look-up tables, A and B, each backed by 16 bits of storage, and two output storage elements. In plain logic mode each table works as an arbitrary function of its four address inputs. The same storage can also serve as user RAM: two independent 16x1 RAMs, one 32x1 RAM addressed with a fifth address bit, or one 16x1 dual-port RAM with a separate read address. Storage element 0 is fed by table output A and storage element 1 by table output B.

Each storage element is independently an edge-triggered flip-flop or a level-sensitive latch. Each has its own clock inversion, clock enable, synchronous set and reset, and asynchronous set and reset. The clock itself is never gated: a disabled element simply holds its value.

Configuration enters as a one-bit valid/ready stream. `cfg_ready` is low only while `rst_n` is low and for the edge that releases it. After that it stays high, so the stream never sees back-pressure. A bit is taken on each rising clock edge where `cfg_valid` and `cfg_ready` are both high. Each accepted bit shifts one place along a 38-bit chain that runs through the control bits and both tables. The sender must present `cfg_data` steady around that edge.

Top module: `clb_cell`

## Requirements
- R1: While `rst_n` is low, both tables and all control bits are cleared, `q` is 0 and `cfg_ready` is 0. `cfg_ready` rises at the first rising edge after release.
- R2: A configuration word W[37:0] is sent most significant bit first, one bit per accepted beat, 38 beats in all. The fields are: W[37:22] table B, W[21:6] table A, W[5] inverts the clock of element 1, W[4] makes element 1 a latch, W[3] inverts the clock of element 0, W[2] makes element 0 a latch, and W[1:0] selects the memory mode. Memory mode codes are 0 logic, 1 two 16x1 RAMs, 2 one 32x1 RAM, 3 dual-port 16x1 RAM. A table bit at index i is the output for address value i.
- R3: In logic mode, `out_a` equals table A at `addr_a` and `out_b` equals table B at `addr_b`. `ram_we` has no effect on either table.
- R4: In mode 1, a rising edge with `ram_we` high writes `din_a` into table A at `addr_a` and `din_b` into table B at `addr_b`. Both reads are combinational.
- R5: In mode 2, `addr_hi` selects the table: 0 for A, 1 for B. `out_a` reads the selected table at `addr_a`, and a write stores `din_a` only into the selected table at `addr_a`. `out_b` still reads table B at `addr_b`.
- R6: In mode 3, a write stores `din_a` at `addr_a` in both tables. `out_b` reads table B at `addr_b`. When `addr_b` equals the written address, `out_b` shows the old value before the edge and the new value after it.
- R7: On an edge where a configuration bit is accepted, any RAM write is dropped. The tables end up holding exactly the shifted configuration word.
- R8: In flip-flop mode, the element captures its data on the rising clock edge, or on the falling edge when its clock is inverted. Its output does not change on the other edge.
- R9: In latch mode, the element is transparent while the clock is high, or while it is low when inverted, and only if its enable is high. It holds its value during the opposite clock level.
- R10: Synchronous reset and set act at the element's capture instant whatever the enable. Reset wins over set, and both win over data.
- R11: Asynchronous reset and set act at once, without a clock. Asynchronous reset wins over asynchronous set, and both override every synchronous control.
- R12: With its enable low and no set or reset active, an element holds its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Active-low asynchronous clear of configuration, tables and elements |
| cfg_valid | input | 1 | Configuration beat present |
| cfg_ready | output | 1 | Configuration beat accepted when high |
| cfg_data | input | 1 | Configuration bit |
| addr_a | input | 4 | Table A address; write address in RAM modes |
| addr_b | input | 4 | Table B address; read port in dual-port mode |
| addr_hi | input | 1 | Fifth address bit in 32x1 mode |
| din_a | input | 1 | Write data for table A (and B in modes 2 and 3) |
| din_b | input | 1 | Write data for table B in mode 1 |
| ram_we | input | 1 | RAM write enable |
| out_a | output | 1 | Table A function or RAM read output |
| out_b | output | 1 | Table B function or RAM read output |
| reg_ce | input | 2 | Clock enable per element |
| reg_sset | input | 2 | Synchronous set per element |
| reg_srst | input | 2 | Synchronous reset per element |
| reg_aset | input | 2 | Asynchronous set per element |
| reg_arst | input | 2 | Asynchronous reset per element |
| q | output | 2 | Storage element outputs |

## Verification
The clocked properties assume the following about the inputs:
- Every input changes between clock edges, never at an edge.
- The configuration is not reloaded while a synchronous set or reset is being applied.
- Asynchronous set and reset pulses that start and end inside one clock phase are not judged by the clocked properties; those pulses are checked directly at the ports.

The stimulus keeps within these limits. It moves inputs a quarter period after the rising edge and holds every element control low while a configuration is shifted in. Latch transparency and the inverted-clock flip-flop are probed at explicit points inside each clock phase, so that each expected value depends on a single clock level.

// File: rtl/clb_pkg.sv
`timescale 1ns/1ps
package clb_pkg;
  typedef enum logic [1:0] {
    MEM_LOGIC = 2'd0,
    MEM_RAM16 = 2'd1,
    MEM_RAM32 = 2'd2,
    MEM_DUAL  = 2'd3
  } mem_mode_e;

  // Control bits in chain order: first field is the most significant.
  typedef struct packed {
    logic      inv1;
    logic      latch1;
    logic      inv0;
    logic      latch0;
    mem_mode_e mode;
  } cell_ctrl_t;

  localparam int CTRL_W = $bits(cell_ctrl_t);
endpackage

// File: rtl/clb_cfg_ctrl.sv
`timescale 1ns/1ps
module clb_cfg_ctrl #(
  parameter int CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              din_i,
  output logic              ready_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_o <= 1'b0;
      ctrl_o  <= '0;
    end else begin
      ready_o <= 1'b1;
      if (shift_i) ctrl_o <= {ctrl_o[CTRL_W-2:0], din_i};
    end
  end

  p_ctrl_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> ctrl_o == {$past(ctrl_o[CTRL_W-2:0]), $past(din_i)});
endmodule

// File: rtl/clb_lut_store.sv
`timescale 1ns/1ps
module clb_lut_store #(
  parameter int LUT_IN = 4,
  localparam int DEPTH = 1 << LUT_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sh_en_i,
  input  logic              sh_in_i,
  input  logic              wr_en_i,
  input  logic [LUT_IN-1:0] wr_addr_i,
  input  logic              wr_data_i,
  output logic [DEPTH-1:0]  tbl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_o <= '0;
    end else if (sh_en_i) begin
      tbl_o <= {tbl_o[DEPTH-2:0], sh_in_i};
    end else if (wr_en_i) begin
      tbl_o[wr_addr_i] <= wr_data_i;
    end
  end

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh_en_i || wr_en_i) |=> $stable(tbl_o));

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !sh_en_i) |=> tbl_o[$past(wr_addr_i)] == $past(wr_data_i));

  p_shift_beats_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en_i |=> tbl_o == {$past(tbl_o[DEPTH-2:0]), $past(sh_in_i)});
endmodule

// File: rtl/clb_cell_reg.sv
`timescale 1ns/1ps
module clb_cell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_mode_i,
  input  logic clk_inv_i,
  input  logic d_i,
  input  logic ce_i,
  input  logic sset_i,
  input  logic srst_i,
  input  logic aset_i,
  input  logic arst_i,
  output logic q_o
);
  logic aclr, apre, ff_pos, ff_neg, lat, open_lvl;

  assign aclr     = arst_i | ~rst_n;
  assign apre     = aset_i & ~aclr;
  assign open_lvl = clk ^ clk_inv_i;

  // Edge version for rising clock
  always_ff @(posedge clk or posedge aclr or posedge apre) begin
    if (aclr)        ff_pos <= 1'b0;
    else if (apre)   ff_pos <= 1'b1;
    else if (srst_i) ff_pos <= 1'b0;
    else if (sset_i) ff_pos <= 1'b1;
    else if (ce_i)   ff_pos <= d_i;
  end

  // Edge version for falling clock (inverted polarity)
  always_ff @(negedge clk or posedge aclr or posedge apre) begin
    if (aclr)        ff_neg <= 1'b0;
    else if (apre)   ff_neg <= 1'b1;
    else if (srst_i) ff_neg <= 1'b0;
    else if (sset_i) ff_neg <= 1'b1;
    else if (ce_i)   ff_neg <= d_i;
  end

  // Level-sensitive version
  always_latch begin
    if (aclr)            lat <= 1'b0;
    else if (apre)       lat <= 1'b1;
    else if (open_lvl) begin
      if (srst_i)        lat <= 1'b0;
      else if (sset_i)   lat <= 1'b1;
      else if (ce_i)     lat <= d_i;
    end
  end

  assign q_o = latch_mode_i ? lat : (clk_inv_i ? ff_neg : ff_pos);

  p_arst_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    arst_i |-> q_o == 1'b0);

  p_aset_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (aset_i && !arst_i) |-> q_o == 1'b1);

  p_srst_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode_i && !clk_inv_i && srst_i && !aset_i && !arst_i)
      |=> (q_o == 1'b0) || aset_i || arst_i);
endmodule

// File: rtl/clb_cell.sv
`timescale 1ns/1ps
module clb_cell
  import clb_pkg::*;
#(
  parameter int LUT_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_data,
  input  logic [LUT_IN-1:0] addr_a,
  input  logic [LUT_IN-1:0] addr_b,
  input  logic              addr_hi,
  input  logic              din_a,
  input  logic              din_b,
  input  logic              ram_we,
  output logic              out_a,
  output logic              out_b,
  input  logic [1:0]        reg_ce,
  input  logic [1:0]        reg_sset,
  input  logic [1:0]        reg_srst,
  input  logic [1:0]        reg_aset,
  input  logic [1:0]        reg_arst,
  output logic [1:0]        q
);
  localparam int DEPTH  = 1 << LUT_IN;
  localparam int N_LUT  = 2;
  localparam int N_REG  = 2;

  logic [CTRL_W-1:0]           ctrl_bits;
  cell_ctrl_t                  ctrl;
  logic                        shift;
  logic [N_LUT-1:0][DEPTH-1:0] tbl;
  logic [N_LUT-1:0]            sh_in, wr_en, wr_data;
  logic [N_LUT-1:0][LUT_IN-1:0] wr_addr;
  logic [N_REG-1:0]            r_latch, r_inv, r_d;
  logic                        m_ram16, m_ram32, m_dual, wr_ok;

  assign shift = cfg_valid & cfg_ready;
  assign ctrl  = cell_ctrl_t'(ctrl_bits);

  clb_cfg_ctrl #(.CTRL_W(CTRL_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift),
    .din_i   (cfg_data),
    .ready_o (cfg_ready),
    .ctrl_o  (ctrl_bits)
  );

  always_comb begin
    m_ram16 = (ctrl.mode == MEM_RAM16);
    m_ram32 = (ctrl.mode == MEM_RAM32);
    m_dual  = (ctrl.mode == MEM_DUAL);
    wr_ok   = ram_we & ~shift;
    // chain: control bits -> table A -> table B
    sh_in[0] = ctrl_bits[CTRL_W-1];
    sh_in[1] = tbl[0][DEPTH-1];
    wr_en[0] = wr_ok & (m_ram16 | m_dual | (m_ram32 & ~addr_hi));
    wr_en[1] = wr_ok & (m_ram16 | m_dual | (m_ram32 &  addr_hi));
    wr_addr[0] = addr_a;
    wr_addr[1] = m_ram16 ? addr_b : addr_a;
    wr_data[0] = din_a;
    wr_data[1] = m_ram16 ? din_b : din_a;
  end

  for (genvar k = 0; k < N_LUT; k++) begin : g_lut
    clb_lut_store #(.LUT_IN(LUT_IN)) u_lut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sh_en_i   (shift),
      .sh_in_i   (sh_in[k]),
      .wr_en_i   (wr_en[k]),
      .wr_addr_i (wr_addr[k]),
      .wr_data_i (wr_data[k]),
      .tbl_o     (tbl[k])
    );
  end

  assign out_a = (m_ram32 && addr_hi) ? tbl[1][addr_a] : tbl[0][addr_a];
  assign out_b = tbl[1][addr_b];

  assign r_latch = {ctrl.latch1, ctrl.latch0};
  assign r_inv   = {ctrl.inv1, ctrl.inv0};
  assign r_d     = {out_b, out_a};

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    clb_cell_reg u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .latch_mode_i (r_latch[r]),
      .clk_inv_i    (r_inv[r]),
      .d_i          (r_d[r]),
      .ce_i         (reg_ce[r]),
      .sset_i       (reg_sset[r]),
      .srst_i       (reg_srst[r]),
      .aset_i       (reg_aset[r]),
      .arst_i       (reg_arst[r]),
      .q_o          (q[r])
    );
  end

  p_logic_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MEM_LOGIC && !shift) |=> $stable(tbl));

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready);
endmodule

// File: tb/clb_cell_tb.sv
`timescale 1ns/1ps
module clb_cell_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic       rst_n, cfg_valid, cfg_ready, cfg_data;
  logic [3:0] addr_a, addr_b;
  logic       addr_hi, din_a, din_b, ram_we, out_a, out_b;
  logic [1:0] reg_ce, reg_sset, reg_srst, reg_aset, reg_arst, q;

  clb_cell u_dut (.*);

  typedef struct {
    string      tag;
    logic [4:0] mask;
    logic [4:0] exp;
  } item_t;
  item_t exp_q[$];

  int n_run = 0, n_fail = 0;
  bit done = 0;

  localparam logic [4:0] M_RDY = 5'b10000, M_Q1 = 5'b01000, M_Q0 = 5'b00100,
                         M_B = 5'b00010, M_A = 5'b00001;

  // Monitor: pops expected items and compares against the observed outputs
  initial forever begin
    item_t it;
    logic [4:0] obs;
    wait (exp_q.size() > 0);
    it  = exp_q.pop_front();
    obs = {cfg_ready, q[1], q[0], out_b, out_a};
    n_run++;
    if (((obs ^ it.exp) & it.mask) != 5'b0) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (mask %b)", it.tag,
               obs & it.mask, it.exp & it.mask, it.mask);
    end
  end

  task automatic chk(string tag, logic [4:0] mask, logic [4:0] exp);
    item_t it;
    it.tag = tag; it.mask = mask; it.exp = exp;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  function automatic logic [37:0] cfg_word(logic [15:0] ta, logic [15:0] tb,
      logic [1:0] mode, logic l0, logic i0, logic l1, logic i1);
    return {tb, ta, i1, l1, i0, l0, mode};
  endfunction

  task automatic load(logic [37:0] w, logic we_hold);
    for (int i = 37; i >= 0; i--) begin
      cfg_valid = 1'b1; cfg_data = w[i]; ram_we = we_hold;
      step();
    end
    cfg_valid = 1'b0; cfg_data = 1'b0; ram_we = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_valid = 0; cfg_data = 0; addr_a = 0; addr_b = 0;
    addr_hi = 0; din_a = 0; din_b = 0; ram_we = 0; reg_ce = 0;
    reg_sset = 0; reg_srst = 0; reg_aset = 0; reg_arst = 0;
    #25;
    chk("R1 reset state", M_RDY | M_Q1 | M_Q0 | M_B | M_A, 5'b00000);
    #10 rst_n = 1;
    step();
    chk("R1 ready after release, tables clear", M_RDY | M_B | M_A, 5'b10000);

    // Config 1: A = addr bit0, B = AND of all four, logic mode, flops, no inversion
    load(cfg_word(16'hAAAA, 16'h8000, 2'd0, 0, 0, 0, 0), 1'b0);
    addr_a = 4'd5; addr_b = 4'd15; #1;
    chk("R2 R3 table readback high", M_A | M_B, 5'b00011);
    addr_a = 4'd4; addr_b = 4'd14; #1;
    chk("R2 R3 table readback low", M_A | M_B, 5'b00000);
    addr_a = 4'd5; din_a = 1'b0; ram_we = 1'b1;
    step(); ram_we = 1'b0; #1;
    chk("R3 write ignored in logic mode", M_A, 5'b00001);

    // Flip-flop behaviour on element 0 (d = out_a)
    reg_ce = 2'b01; addr_a = 4'd1;
    step();
    chk("R8 rising capture", M_Q0, 5'b00100);
    addr_a = 4'd0; #5;
    chk("R8 no change at falling edge", M_Q0, 5'b00100);
    step();
    chk("R8 captures new data", M_Q0, 5'b00000);
    reg_ce = 2'b00; addr_a = 4'd1;
    step();
    chk("R12 enable low holds", M_Q0, 5'b00000);
    reg_sset = 2'b01; addr_a = 4'd0;
    step();
    chk("R10 sync set regardless of enable", M_Q0, 5'b00100);
    reg_srst = 2'b01;
    step();
    chk("R10 sync reset wins over set", M_Q0, 5'b00000);
    reg_srst = 0;
    step();
    reg_sset = 0; #1;
    reg_arst = 2'b01; #1;
    chk("R11 async reset immediate", M_Q0, 5'b00000);
    reg_aset = 2'b01; #1;
    chk("R11 async reset wins over async set", M_Q0, 5'b00000);
    reg_arst = 0; #1;
    chk("R11 async set immediate", M_Q0, 5'b00100);
    reg_aset = 0; reg_arst = 2'b01; reg_sset = 2'b01;
    step();
    chk("R11 async reset overrides sync set", M_Q0, 5'b00000);
    reg_arst = 0; reg_sset = 0;
    step();

    // Config 2: element 0 latch, element 1 flop on falling edge, two 16x1 RAMs
    load(cfg_word(16'hAAAA, 16'hAAAA, 2'd1, 1, 0, 0, 1), 1'b0);
    reg_ce = 2'b11; addr_a = 4'd1; addr_b = 4'd0; #1;
    chk("R9 latch transparent while clock high", M_Q0, 5'b00100);
    #5; addr_a = 4'd0; #1;
    chk("R9 latch holds while clock low", M_Q0 | M_A, 5'b00100);
    @(posedge clk); #1;
    chk("R9 latch reopens on high level", M_Q0, 5'b00000);
    #4; addr_b = 4'd1; #4;
    chk("R8 inverted flop ignores rising edge", M_Q1, 5'b00000);
    #2;
    chk("R8 inverted flop captures at falling edge", M_Q1, 5'b01000);
    step();
    reg_ce = 2'b00;
    addr_a = 4'd2; din_a = 1'b1; addr_b = 4'd3; din_b = 1'b0; ram_we = 1'b1;
    step(); ram_we = 1'b0; #1;
    chk("R4 independent 16x1 writes", M_A | M_B, 5'b00001);

    // Config 3 loaded while a write is requested: writes must be dropped
    addr_a = 4'd0; din_a = 1'b1;
    load(cfg_word(16'h0000, 16'hFFFF, 2'd2, 0, 0, 0, 0), 1'b1);
    addr_hi = 1'b0; addr_a = 4'd0; addr_b = 4'd0; #1;
    chk("R7 config beats RAM write", M_A | M_B, 5'b00010);
    addr_hi = 1'b1; #1;
    chk("R5 high address selects table B", M_A, 5'b00001);
    addr_a = 4'd4; din_a = 1'b0; ram_we = 1'b1;
    step(); ram_we = 1'b0; addr_b = 4'd4; #1;
    chk("R5 write lands in table B only", M_A | M_B, 5'b00000);
    addr_hi = 1'b0; addr_a = 4'd6; din_a = 1'b1; ram_we = 1'b1;
    step(); ram_we = 1'b0; #1;
    chk("R5 write lands in table A", M_A, 5'b00001);
    addr_hi = 1'b1; addr_a = 4'd4; #1;
    chk("R5 table B untouched by A write", M_A, 5'b00000);
    addr_hi = 1'b0;

    // Config 4: dual-port 16x1
    load(cfg_word(16'h0000, 16'h0000, 2'd3, 0, 0, 0, 0), 1'b0);
    addr_a = 4'd9; addr_b = 4'd9; din_a = 1'b1; ram_we = 1'b1; #1;
    chk("R6 read port old value before edge", M_B, 5'b00000);
    step(); ram_we = 1'b0; #1;
    chk("R6 read port new value after edge", M_A | M_B, 5'b00011);
    addr_b = 4'd8; #1;
    chk("R6 other location unchanged", M_B, 5'b00000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule